// File: doc/BRIEF.md
# Direction-Configurable Word Serializer Link

This block forms one end of a source-synchronous serial link. When reset is released it reads a direction pin and takes one of two roles for the rest of the run. As a serializer, it captures a 24-bit parallel word on each rising edge of a strobe. It sends the word bit by bit on a serial data line next to a forwarded bit clock. As a deserializer, it takes that forwarded clock and data, finds where each word ends, and presents the word on a parallel output together with a one-cycle word clock pulse.

No separate framing wire is used. Each word occupies 26 bit slots. The forwarded clock pulses in the 24 data slots and stays low through the last two slots, so the word boundary is the gap in the clock. Everything runs on one system clock. An external bit-rate enable sets the slot pace, and each slot spans two enable ticks. A strobe that arrives while a word is still going out is held in a one-word buffer. A further early strobe is dropped and raises a sticky overflow flag.

Top module: `wordlink`

## Requirements
- R1: The role is taken from `role_sel` during reset (1 = serializer, 0 = deserializer). Changes of `role_sel` after reset is released have no effect until the next reset.
- R2: In serializer role, `par_in` is captured only on a rising edge of `strobe`. Holding `strobe` high starts no further frame.
- R3: A frame has 26 slots of two bit-enable ticks each. In slots 0 to 23, `ser_out` carries word bit n in slot n (LSB first) for the whole slot. `fwd_clk_out` is low in the first tick of the slot and high in the second tick.
- R4: In slots 24 and 25, `fwd_clk_out` stays low. Each accepted word produces exactly 24 rising edges of `fwd_clk_out`.
- R5: A strobe that arrives during a frame while the buffer is empty is stored. Its word is sent directly after the current frame, with no idle slot between the frames.
- R6: A strobe that arrives during a frame while the buffer is full is dropped. It sets `overflow`, which stays high until the next reset.
- R7: In deserializer role, `ser_in` is shifted in at each rising edge of `fwd_clk_in`. When `fwd_clk_in` then stays low for 5 bit-enable ticks, and exactly 24 bits were taken, the word appears on `par_out` with a one-cycle `word_clk` pulse.
- R8: A frame with any bit count other than 24 is discarded without a `word_clk` pulse. An idle link produces no pulses.
- R9: In serializer role, `word_clk` never pulses. In deserializer role, `fwd_clk_out` and `ser_out` stay low and `strobe` is ignored.
- R10: After reset, `fwd_clk_out`, `ser_out`, `word_clk` and `overflow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Bit-rate enable, one tick per half slot |
| role_sel | input | 1 | Direction pin, sampled during reset (1 = serializer) |
| strobe | input | 1 | Word strobe, rising edge captures `par_in` |
| par_in | input | W (24) | Parallel word to send |
| fwd_clk_in | input | 1 | Forwarded bit clock from the far end |
| ser_in | input | 1 | Serial data from the far end |
| fwd_clk_out | output | 1 | Forwarded bit clock with gap at word boundary |
| ser_out | output | 1 | Serial data, LSB first |
| par_out | output | W (24) | Last recovered word |
| word_clk | output | 1 | One-cycle pulse per recovered word |
| overflow | output | 1 | Sticky flag for a strobe lost to a full buffer |

## Verification
A correct serializer never sends a frame with a wrong bit count, so the rejection of short and long frames cannot be reached through a loopback. The bench therefore switches the receiving instance's inputs to a bench-driven forwarded clock and data. It then plays frames of 23, 25 and 24 bits, each followed by a low gap. The overflow case needs a third strobe to arrive after the first frame has started and before the buffered word has been handed over. The bench issues three strobes within a few dozen cycles, well inside a frame of about a hundred cycles.

// File: rtl/wl_pkg.sv
// Shared types for the word link.
package wl_pkg;
    // Role taken at reset release.
    typedef enum logic {
        ROLE_RX = 1'b0,
        ROLE_TX = 1'b1
    } role_e;
endpackage

// File: rtl/wl_tx.sv
// Serializer half of the word link.
// Captures a word on each strobe rising edge and sends it over W+GAP slots.
// Each slot takes two bit_en ticks: the clock is low in the first tick and
// high in the second, but only in data slots. A one-word buffer holds an
// early strobe.
// Assumes: strobe is synchronous to clk; bit_en is a single-cycle enable.
module wl_tx #(
    parameter int unsigned W   = 24,
    parameter int unsigned GAP = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_en,
    input  logic         active,
    input  logic         strobe,
    input  logic [W-1:0] par_in,
    output logic         fwd_clk,
    output logic         ser_data,
    output logic         overflow
);
    localparam int unsigned SLOTS = W + GAP;
    localparam int unsigned SW    = $clog2(SLOTS);

    logic          stb_q;
    logic          busy;
    logic          ph;
    logic [SW-1:0] slot;
    logic [W-1:0]  cur;
    logic [W-1:0]  hold;
    logic          pend;
    logic          ovf;
    logic          stb_rise;
    logic          in_data;
    logic          frame_end;

    assign stb_rise  = active & strobe & ~stb_q;
    assign in_data   = busy & (slot < SW'(W));
    assign frame_end = busy & bit_en & ph & (slot == SW'(SLOTS - 1));
    assign fwd_clk   = in_data & ph;
    assign ser_data  = in_data & cur[0];
    assign overflow  = ovf;

    // Remember the previous strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) stb_q <= 1'b0;
        else        stb_q <= strobe;
    end

    // Slot sequencing, word hand-over and strobe capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            ph   <= 1'b0;
            slot <= '0;
            cur  <= '0;
            hold <= '0;
            pend <= 1'b0;
            ovf  <= 1'b0;
        end else begin
            if (busy && bit_en) begin
                ph <= ~ph;
                if (ph) begin
                    cur <= cur >> 1;
                    if (slot == SW'(SLOTS - 1)) begin
                        slot <= '0;
                        if (pend) begin
                            cur  <= hold;
                            pend <= 1'b0;
                        end else begin
                            busy <= 1'b0;
                        end
                    end else begin
                        slot <= slot + SW'(1);
                    end
                end
            end
            if (stb_rise) begin
                if (!busy) begin
                    cur  <= par_in;
                    busy <= 1'b1;
                    slot <= '0;
                    ph   <= 1'b0;
                end else if (frame_end && !pend) begin
                    cur  <= par_in;
                    busy <= 1'b1;
                end else if (frame_end || !pend) begin
                    hold <= par_in;
                    pend <= 1'b1;
                end else begin
                    ovf <= 1'b1;
                end
            end
        end
    end

    AST_CLK_ONLY_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_clk |-> (busy && slot < SW'(W))); // R4
    AST_NO_OVERFLOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf); // R6
    AST_PEND_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> busy); // R5
endmodule

// File: rtl/wl_rx.sv
// Deserializer half of the word link.
// Shifts serial data in on each forwarded-clock rising edge. It treats
// 2*GAP+1 bit_en ticks without a rising edge as a word boundary, and
// publishes the word only if exactly W bits arrived since the last boundary.
// Assumes: fwd_clk and ser_data are synchronous to clk.
module wl_rx #(
    parameter int unsigned W   = 24,
    parameter int unsigned GAP = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_en,
    input  logic         active,
    input  logic         fwd_clk,
    input  logic         ser_data,
    output logic [W-1:0] par_out,
    output logic         word_clk
);
    localparam int unsigned LIM = 2 * GAP + 1;
    localparam int unsigned GW  = $clog2(LIM + 1);
    localparam int unsigned CW  = $clog2(W + 2);

    logic          fq;
    logic          rise;
    logic [GW-1:0] gap;
    logic [CW-1:0] cnt;
    logic [W-1:0]  sh;
    logic          boundary;

    assign rise     = active & fwd_clk & ~fq;
    assign boundary = ~rise & bit_en & (gap == GW'(LIM - 1));

    // Track the forwarded clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) fq <= 1'b0;
        else        fq <= fwd_clk;
    end

    // Measure ticks since the last clock edge, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                          gap <= GW'(LIM);
        else if (rise)                       gap <= '0;
        else if (bit_en && gap != GW'(LIM))  gap <= gap + GW'(1);
    end

    // Shift in data and count bits, saturating one past a full word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            sh  <= '0;
        end else if (rise) begin
            sh <= {ser_data, sh[W-1:1]};
            if (cnt != CW'(W + 1)) cnt <= cnt + CW'(1);
        end else if (boundary) begin
            cnt <= '0;
        end
    end

    // Publish a full word at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_out  <= '0;
            word_clk <= 1'b0;
        end else begin
            word_clk <= boundary && (cnt == CW'(W));
            if (boundary && cnt == CW'(W)) par_out <= sh;
        end
    end

    AST_WCLK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        word_clk |=> !word_clk); // R7
    AST_WCLK_AT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        word_clk |-> (gap == GW'(LIM) && cnt == '0)); // R8
endmodule

// File: rtl/wordlink.sv
// Top of the word link: latches the role during reset and enables one half.
// Assumes: role_sel is stable in the last reset cycle.
module wordlink
    import wl_pkg::*;
#(
    parameter int unsigned W   = 24,
    parameter int unsigned GAP = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_en,
    input  logic         role_sel,
    input  logic         strobe,
    input  logic [W-1:0] par_in,
    input  logic         fwd_clk_in,
    input  logic         ser_in,
    output logic         fwd_clk_out,
    output logic         ser_out,
    output logic [W-1:0] par_out,
    output logic         word_clk,
    output logic         overflow
);
    role_e role_q;
    logic  tx_act;
    logic  rx_act;

    // Follow the direction pin during reset, then hold it.
    always_ff @(posedge clk) begin
        if (!rst_n) role_q <= role_e'(role_sel);
    end

    assign tx_act = (role_q == ROLE_TX);
    assign rx_act = (role_q == ROLE_RX);

    wl_tx #(.W(W), .GAP(GAP)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .active   (tx_act),
        .strobe   (strobe),
        .par_in   (par_in),
        .fwd_clk  (fwd_clk_out),
        .ser_data (ser_out),
        .overflow (overflow)
    );

    wl_rx #(.W(W), .GAP(GAP)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .active   (rx_act),
        .fwd_clk  (fwd_clk_in),
        .ser_data (ser_in),
        .par_out  (par_out),
        .word_clk (word_clk)
    );

    AST_ROLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(role_q)); // R1
    AST_TX_NO_WCLK: assert property (@(posedge clk) disable iff (!rst_n)
        tx_act |-> !word_clk); // R9
    AST_RX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rx_act |-> (!fwd_clk_out && !ser_out)); // R9
endmodule

// File: tb/wordlink_tb.sv
module wordlink_tb;
    localparam int W = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0;
    logic dut_role = 1'b1;
    logic strobe = 1'b0;
    logic [W-1:0] par_in = '0;
    logic man = 1'b0;
    logic man_fwd = 1'b0;
    logic man_ser = 1'b0;

    logic dut_fwd, dut_ser, dut_wclk, dut_ovf;
    logic [W-1:0] dut_par;
    logic rx_fwd_o, rx_ser_o, rx_wclk, rx_ovf;
    logic [W-1:0] rx_par;
    logic rx_fwd_i, rx_ser_i;

    int errors = 0;
    int checks = 0;
    int rx_n = 0;
    int fwd_rises = 0;
    int dut_wclk_n = 0;
    logic [W-1:0] rx_q [0:63];
    logic [W-1:0] tx_cap = '0;
    logic prev_fwd = 1'b0;

    always #4 clk = ~clk;

    assign rx_fwd_i = man ? man_fwd : dut_fwd;
    assign rx_ser_i = man ? man_ser : dut_ser;

    wordlink #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .role_sel(dut_role),
        .strobe(strobe), .par_in(par_in), .fwd_clk_in(1'b0), .ser_in(1'b0),
        .fwd_clk_out(dut_fwd), .ser_out(dut_ser), .par_out(dut_par),
        .word_clk(dut_wclk), .overflow(dut_ovf)
    );

    wordlink #(.W(W)) u_peer (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .role_sel(1'b0),
        .strobe(strobe), .par_in(par_in), .fwd_clk_in(rx_fwd_i), .ser_in(rx_ser_i),
        .fwd_clk_out(rx_fwd_o), .ser_out(rx_ser_o), .par_out(rx_par),
        .word_clk(rx_wclk), .overflow(rx_ovf)
    );

    // Bit-rate enable: one tick every second clock.
    initial forever begin
        @(negedge clk);
        bit_en = ~bit_en;
    end

    // Monitor both instances away from the active edge.
    always @(negedge clk) begin
        if (rx_wclk) begin
            if (rx_n < 64) rx_q[rx_n] = rx_par;
            rx_n = rx_n + 1;
        end
        if (dut_wclk) dut_wclk_n = dut_wclk_n + 1;
        if (dut_fwd && !prev_fwd) begin
            fwd_rises = fwd_rises + 1;
            tx_cap = {dut_ser, tx_cap[W-1:1]};
        end
        prev_fwd = dut_fwd;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic role);
        @(negedge clk);
        rst_n = 1'b0;
        dut_role = role;
        strobe = 1'b0;
        cycles(4);
        rst_n = 1'b1;
        cycles(1);
        rx_n = 0;
        fwd_rises = 0;
        dut_wclk_n = 0;
    endtask

    task automatic send_word(input logic [W-1:0] w);
        @(negedge clk);
        par_in = w;
        strobe = 1'b1;
        cycles(2);
        strobe = 1'b0;
    endtask

    task automatic man_frame(input int nbits, input logic [31:0] d);
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            man_fwd = 1'b0;
            man_ser = d[i];
            cycles(2);
            man_fwd = 1'b1;
            cycles(2);
        end
        man_fwd = 1'b0;
        man_ser = 1'b0;
        cycles(20);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors = errors + 1;
        checks = checks + 1;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [W-1:0] w;
        do_reset(1'b1);
        // R10 reset state
        chk(dut_fwd == 1'b0 && dut_ser == 1'b0, "R10 tx lines", {dut_fwd, dut_ser}, 0);
        chk(dut_ovf == 1'b0, "R10 overflow", dut_ovf, 0);
        chk(rx_wclk == 1'b0, "R10 word_clk", rx_wclk, 0);

        // Sweep: walking ones plus fixed patterns through the loopback.
        for (int i = 0; i < W + 3; i++) begin
            if (i < W)       w = W'(1) << i;
            else if (i == W) w = '0;
            else if (i == W + 1) w = '1;
            else             w = 24'hA5C31E;
            send_word(w);
            cycles(140);
            chk(tx_cap == w, "R3 tx bit order", tx_cap, w);
            chk(fwd_rises == W * (i + 1), "R4 clock pulses", fwd_rises, W * (i + 1));
            chk(rx_n == i + 1, "R7 word count", rx_n, i + 1);
            if (rx_n == i + 1) chk(rx_q[i] == w, "R7 word value", rx_q[i], w);
        end
        chk(dut_wclk_n == 0, "R9 serializer word_clk", dut_wclk_n, 0);

        // R5 buffered strobe, back-to-back frames.
        do_reset(1'b1);
        send_word(24'h123456);
        cycles(20);
        send_word(24'hFEDCBA);
        cycles(300);
        chk(rx_n == 2, "R5 two words", rx_n, 2);
        chk(rx_q[0] == 24'h123456, "R5 first word", rx_q[0], 24'h123456);
        chk(rx_q[1] == 24'hFEDCBA, "R5 second word", rx_q[1], 24'hFEDCBA);
        chk(dut_ovf == 1'b0, "R5 no overflow", dut_ovf, 0);

        // R6 overflow on a third early strobe.
        do_reset(1'b1);
        send_word(24'h0F0F0F);
        cycles(20);
        send_word(24'h333333);
        cycles(10);
        send_word(24'h555555);
        cycles(3);
        chk(dut_ovf == 1'b1, "R6 overflow set", dut_ovf, 1);
        cycles(400);
        chk(rx_n == 2, "R6 dropped word", rx_n, 2);
        chk(rx_q[1] == 24'h333333, "R6 buffered word kept", rx_q[1], 24'h333333);
        chk(dut_ovf == 1'b1, "R6 overflow sticky", dut_ovf, 1);

        // R2 strobe held high: one capture only.
        do_reset(1'b1);
        @(negedge clk);
        par_in = 24'hABCDEF;
        strobe = 1'b1;
        cycles(150);
        par_in = 24'h111111;
        cycles(300);
        strobe = 1'b0;
        cycles(150);
        chk(rx_n == 1, "R2 single capture", rx_n, 1);
        chk(rx_q[0] == 24'hABCDEF, "R2 captured value", rx_q[0], 24'hABCDEF);

        // R1 pin changes after reset are ignored.
        do_reset(1'b1);
        dut_role = 1'b0;
        send_word(24'h7E7E7E);
        cycles(140);
        chk(rx_n == 1 && rx_q[0] == 24'h7E7E7E, "R1 role kept serializer", rx_n, 1);
        do_reset(1'b0);
        dut_role = 1'b1;
        send_word(24'h7E7E7E);
        cycles(140);
        chk(fwd_rises == 0, "R1 R9 deserializer stays quiet", fwd_rises, 0);
        chk(rx_n == 0, "R9 nothing received", rx_n, 0);

        // R8 malformed frames, then R7 a good hand-driven frame.
        do_reset(1'b1);
        man = 1'b1;
        cycles(20);
        man_frame(23, 32'h00C0FFEE);
        chk(rx_n == 0, "R8 short frame", rx_n, 0);
        man_frame(25, 32'h01BEEF01);
        chk(rx_n == 0, "R8 long frame", rx_n, 0);
        man_frame(24, 32'h00D1CE5A);
        chk(rx_n == 1, "R7 good frame", rx_n, 1);
        if (rx_n == 1) chk(rx_q[0] == 24'hD1CE5A, "R7 good value", rx_q[0], 24'hD1CE5A);
        cycles(200);
        chk(rx_n == 1, "R8 idle no pulse", rx_n, 1);
        man = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule